// File: doc/BRIEF.md
# Half-Band Low-Pass FIR Datapath

This block is the arithmetic core of a rate-changing low-pass filter. It holds a fixed set of 55 symmetric coefficients with the half-band property: apart from the centre tap, every tap at an even distance from the centre is zero. The two samples that share a coefficient are added before the multiply. Only 14 pair products and one centre product are formed per output, and an adder tree reduces them to a full-precision result.

A sequencer drives it one sample per enabled clock. For 1:2 interpolation the sequencer asserts the zero-stuff select on alternate enabled clocks, which pushes a zero into the delay line in place of the input word. Because of those zeros the passband gain falls by half, and the unity-gain variant sets the doubling control to restore it. For decimation the sequencer simply keeps every second result. Rounding, limiting and output formatting are left to the stage that follows, which receives a result wide enough that no input stream can wrap it.

Coefficients are signed with 16 fraction bits, so the centre tap is one half and the taps sum to exactly 1.0 (65536). With the doubling control low, a constant input `x` therefore settles to `x * 65536`.

Top module: `hb_fir_core`

## Requirements
- R1: While `rst_ni` is low, `acc_o` is zero and all pipeline state is cleared. After reset is released, an all-zero input stream keeps `acc_o` at zero.
- R2: Let sample `x` enter on enabled clock edge k, with all other entered samples zero. Then `acc_o` after enabled edge k+7+n equals `x*h[n]` for n = 0..54, and equals zero at every other enabled edge.
- R3: Coefficients are signed with 16 fraction bits. h[27] = 32768, and h[n] = h[54-n]. For d = |27-n|, h[n] is zero when d is even and nonzero. For odd d the values are: d=1: 20830, d=3: -6774, d=5: 3878, d=7: -2579, d=9: 1819, d=11: -1312, d=13: 949, d=15: -679, d=17: 476, d=19: -324, d=21: 213, d=23: -137, d=25: 88, d=27: -64.
- R4: For an impulse at enabled edge k, the first nonzero result appears after edge k+7, the peak (`x*32768`) appears after edge k+34, and the last nonzero result appears after edge k+61.
- R5: For any input stream, `acc_o` after enabled edge m equals the sum over j of `h[j]*s[m-7-j]`, where s[i] is the value entered at enabled edge i. A constant input `x` settles to `x*65536`.
- R6: When `zero_i` is high on an enabled edge, a zero is entered in place of `sample_i`, whatever `sample_i` holds.
- R7: When `en_i` is low, no pipeline stage moves: `acc_o` holds its value and the sample on `sample_i` is not entered. Latency is counted in enabled edges only.
- R8: When `dbl_i` is high on an enabled edge, the result produced at that edge is exactly twice the value of R5, so it is even.
- R9: `acc_o` is exact for any stream of full-scale inputs (-2048..2047) with doubling applied. Its magnitude never exceeds 2*2048*113012.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advances the whole pipeline by one sample |
| zero_i | input | 1 | Enter a zero instead of the input sample |
| dbl_i | input | 1 | Double the result produced at this edge |
| sample_i | input | 12 | Two's-complement input sample, bit 11 is the sign |
| acc_o | output | 37 | Full-precision signed filter result |

## Verification
A scoreboard convolves every entered value with its own copy of the coefficient table and compares the result on each clock. Impulses of both signs are checked at the first, peak and last response edges. A pipeline off by one register would shift every value. A coefficient with a wrong sign, or a pair mis-wired across the centre, would corrupt the mirrored half of the response. Stuffed zeros with garbage on the data pins expose a mux that lets data through. Random stalls expose a stage that keeps moving without enable. A worst-case full-scale sign pattern with doubling exposes any accumulator too narrow for the peak sum.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int NTAPS    = 55;
  localparam int CTR      = (NTAPS - 1) / 2;
  localparam int NPAIR    = (CTR + 1) / 2;
  localparam int NPROD    = NPAIR + 1;
  localparam int FRAC     = 16;
  localparam int CTR_COEF = 1 << (FRAC - 1);

  // coefficient by odd distance from the centre tap
  function automatic int side_coef(int d);
    case (d)
      1:  return 20830;
      3:  return -6774;
      5:  return 3878;
      7:  return -2579;
      9:  return 1819;
      11: return -1312;
      13: return 949;
      15: return -679;
      17: return 476;
      19: return -324;
      21: return 213;
      23: return -137;
      25: return 88;
      27: return -64;
      default: return 0;
    endcase
  endfunction

  function automatic int abs_coef_sum();
    int s;
    s = CTR_COEF;
    for (int d = 1; d <= CTR; d += 2) begin
      s += (side_coef(d) < 0) ? -2 * side_coef(d) : 2 * side_coef(d);
    end
    return s;
  endfunction
endpackage

// File: rtl/hb_tap_line.sv
module hb_tap_line
  import hb_pkg::*;
#(
  parameter int IN_W = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   zero_i,
  input  logic signed [IN_W-1:0] sample_i,
  output logic signed [IN_W-1:0] lo_o [NPAIR],
  output logic signed [IN_W-1:0] hi_o [NPAIR],
  output logic signed [IN_W-1:0] mid_o
);
  logic signed [IN_W-1:0] in_q;
  logic signed [IN_W-1:0] dl [NTAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q <= '0;
      for (int i = 0; i < NTAPS; i++) dl[i] <= '0;
    end else if (en_i) begin
      in_q  <= zero_i ? '0 : sample_i;
      dl[0] <= in_q;
      for (int i = 1; i < NTAPS; i++) dl[i] <= dl[i-1];
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign lo_o[p] = dl[2*p];
    assign hi_o[p] = dl[NTAPS-1-2*p];
  end
  assign mid_o = dl[CTR];

  assert_zero_stuff_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && zero_i) |=> (in_q == '0));

  assert_line_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(in_q) && $stable(dl[NTAPS-1])));
endmodule

// File: rtl/hb_pair_mac.sv
module hb_pair_mac
  import hb_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int COEF_W = 18,
  parameter int PROD_W = IN_W + 1 + COEF_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [IN_W-1:0]   lo_i [NPAIR],
  input  logic signed [IN_W-1:0]   hi_i [NPAIR],
  input  logic signed [IN_W-1:0]   mid_i,
  output logic signed [PROD_W-1:0] prod_o [NPROD]
);
  localparam int PA_W = IN_W + 1;
  localparam logic signed [COEF_W-1:0] MID_K = COEF_W'(CTR_COEF);

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam logic signed [COEF_W-1:0] K = COEF_W'(side_coef(CTR - 2*p));
    logic signed [PA_W-1:0]   pa;
    logic signed [PROD_W-1:0] pr;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pa <= '0;
        pr <= '0;
      end else if (en_i) begin
        pa <= PA_W'(lo_i[p]) + PA_W'(hi_i[p]);
        pr <= PROD_W'(pa) * PROD_W'(K);
      end
    end
    assign prod_o[p] = pr;
  end

  logic signed [PA_W-1:0]   mq;
  logic signed [PROD_W-1:0] mp;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mq <= '0;
      mp <= '0;
    end else if (en_i) begin
      mq <= PA_W'(mid_i);
      mp <= PROD_W'(mq) * PROD_W'(MID_K);
    end
  end
  assign prod_o[NPAIR] = mp;
endmodule

// File: rtl/hb_sum_tree.sv
module hb_sum_tree #(
  parameter int LEAF_W = 31,
  parameter int ACC_W  = 37,
  parameter int NIN    = 15
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     dbl_i,
  input  logic signed [LEAF_W-1:0] leaf_i [NIN],
  output logic signed [ACC_W-1:0]  sum_o
);
  localparam int LVL   = $clog2(NIN);
  localparam int NLEAF = 1 << LVL;

  // heap order: node n has children 2n and 2n+1, leaves at NLEAF..
  logic signed [ACC_W-1:0] node [1:2*NLEAF-1];

  for (genvar j = 0; j < NLEAF; j++) begin : g_leaf
    if (j < NIN) begin : g_used
      assign node[NLEAF+j] = ACC_W'(leaf_i[j]);
    end else begin : g_pad
      assign node[NLEAF+j] = '0;
    end
  end

  for (genvar n = 1; n < NLEAF; n++) begin : g_node
    logic signed [ACC_W-1:0] q;
    if (n == 1) begin : g_root
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= '0;
        else if (en_i) q <= dbl_i ? ((node[2] + node[3]) <<< 1) : (node[2] + node[3]);
      end
    end else begin : g_inner
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= '0;
        else if (en_i) q <= node[2*n] + node[2*n+1];
      end
    end
    assign node[n] = q;
  end

  assign sum_o = node[1];
endmodule

// File: rtl/hb_fir_core.sv
module hb_fir_core
  import hb_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int COEF_W = 18,
  localparam int ACC_W = IN_W + COEF_W + $clog2(NTAPS) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    zero_i,
  input  logic                    dbl_i,
  input  logic signed [IN_W-1:0]  sample_i,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam int PROD_W = IN_W + 1 + COEF_W;
  localparam longint LIM = 2 * longint'(abs_coef_sum()) * (longint'(1) << (IN_W - 1));

  logic signed [IN_W-1:0]   lo [NPAIR];
  logic signed [IN_W-1:0]   hi [NPAIR];
  logic signed [IN_W-1:0]   mid;
  logic signed [PROD_W-1:0] prod [NPROD];

  hb_tap_line #(.IN_W(IN_W)) u_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .zero_i   (zero_i),
    .sample_i (sample_i),
    .lo_o     (lo),
    .hi_o     (hi),
    .mid_o    (mid)
  );

  hb_pair_mac #(.IN_W(IN_W), .COEF_W(COEF_W), .PROD_W(PROD_W)) u_mac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .lo_i   (lo),
    .hi_i   (hi),
    .mid_i  (mid),
    .prod_o (prod)
  );

  hb_sum_tree #(.LEAF_W(PROD_W), .ACC_W(ACC_W), .NIN(NPROD)) u_tree (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .dbl_i  (dbl_i),
    .leaf_i (prod),
    .sum_o  (acc_o)
  );

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (acc_o == '0) else $error("acc not cleared in reset");
    end
  end

  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_o));

  assert_double_even_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dbl_i) |=> !acc_o[0]);

  assert_no_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (longint'(acc_o) <= LIM) && (longint'(acc_o) >= -LIM));
endmodule

// File: tb/hb_fir_core_tb.sv
module hb_fir_core_tb;
  localparam int IN_W  = 12;
  localparam int ACC_W = IN_W + 18 + 6 + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, zero = 1'b0, dbl = 1'b0;
  logic signed [IN_W-1:0]  smp = '0;
  logic signed [ACC_W-1:0] acc;

  always #4 clk = ~clk;

  hb_fir_core #(.IN_W(IN_W), .COEF_W(18)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .en_i (en), .zero_i (zero),
    .dbl_i (dbl), .sample_i (smp), .acc_o (acc)
  );

  int checks = 0, fails = 0;
  string tag = "R1";
  longint xs [0:4095];
  int ne = 0;
  longint last_exp = 0;
  longint expq [$];
  string  tagq [$];
  int unsigned lf = 32'h1234_5678;

  function automatic longint hc(int n);
    int d;
    d = (n > 27) ? n - 27 : 27 - n;
    if (d == 0) return 32768;
    case (d)
      1: return 20830;   3: return -6774;  5: return 3878;   7: return -2579;
      9: return 1819;   11: return -1312; 13: return 949;   15: return -679;
      17: return 476;   19: return -324;  21: return 213;   23: return -137;
      25: return 88;    27: return -64;
      default: return 0;
    endcase
  endfunction

  task automatic check(string t, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  // driver: set inputs for the next edge and queue the expected result
  task automatic step(logic e, logic z, logic d, int s);
    longint y;
    @(negedge clk);
    en = e; zero = z; dbl = d; smp = IN_W'(s);
    if (e) begin
      y = 0;
      for (int j = 0; j < 55; j++)
        if (ne - 7 - j >= 0) y += hc(j) * xs[ne-7-j];
      if (d) y = 2 * y;
      xs[ne] = z ? 0 : longint'(s);
      ne++;
      last_exp = y;
    end
    expq.push_back(last_exp);
    tagq.push_back(tag);
  endtask

  // monitor
  initial begin
    longint e;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        e = expq.pop_front();
        t = tagq.pop_front();
        check(t, longint'(acc), e);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    finish_run();
  end

  task automatic impulse(int x);
    step(1, 0, 0, x);
    for (int k = 1; k <= 70; k++) begin
      step(1, 0, 0, 0);
      if (k == 6 || k == 7 || k == 34 || k == 61 || k == 62) begin
        @(posedge clk); #2;
        case (k)
          6:  check("R4 before first", longint'(acc), 0);
          7:  check("R4 first", longint'(acc), longint'(x) * hc(0));
          34: check("R4 peak", longint'(acc), longint'(x) * 32768);
          61: check("R4 last", longint'(acc), longint'(x) * hc(54));
          default: check("R4 after last", longint'(acc), 0);
        endcase
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) xs[i] = 0;
    #20;
    check("R1 reset", longint'(acc), 0);
    @(negedge clk); rst_n = 1'b1;

    tag = "R1";
    for (int k = 0; k < 12; k++) step(1, 0, 0, 0);

    tag = "R2 R3";
    impulse(1000);
    impulse(-2048);

    tag = "R5 step";
    for (int k = 0; k < 70; k++) step(1, 0, 0, 1500);
    @(posedge clk); #2;
    check("R5 settled", longint'(acc), 1500 * 65536);

    tag = "R5 random";
    for (int k = 0; k < 120; k++) begin
      lf = lf * 1103515245 + 12345;
      step(1, 0, 0, int'($signed(lf[27:16])));
    end

    tag = "R6";
    for (int k = 0; k < 130; k++) step(1, k[0], 0, k[0] ? 1234 : 700);

    tag = "R7";
    for (int k = 0; k < 150; k++) begin
      lf = lf * 1103515245 + 12345;
      step(lf[20] | lf[21], 0, 0, int'($signed(lf[27:16])));
    end
    for (int k = 0; k < 5; k++) step(0, 0, 1, 2047);

    tag = "R8";
    for (int k = 0; k < 80; k++) begin
      lf = lf * 1103515245 + 12345;
      step(1, 0, 1, (k < 40) ? 900 : int'($signed(lf[27:16])));
    end

    tag = "R9";
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < 55; i++) step(1, 0, 1, (hc(i) >= 0) ? 2047 : -2048);
    for (int k = 0; k < 62; k++) step(1, 0, 1, (k[0]) ? 2047 : -2048);

    tag = "R1 flush";
    for (int k = 0; k < 70; k++) step(1, 0, 0, 0);
    @(posedge clk); #2;
    check("R1 zero after flush", longint'(acc), 0);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule